// File: doc/BRIEF.md
# Character Cell Pixel Row Generator

This block turns a character code and a scan line number into the pixel pattern of one line of a text cell. The cell is 9 pixels wide and 15 lines tall. The glyph store is only 8 bits wide, so the block rebuilds the ninth pixel from the stored byte. Two storage formats are supported:

- **Alphanumeric format:** seven pixel bits and one half-shift bit per line. The half-shift bit sets where the seven-pixel glyph sits in the cell.
- **Full-width format:** the lowest stored bit is doubled, so an 8-bit word fills all 9 pixels.

The glyph store is qualified by four enable inputs, combined in one of two styles. When the store is not enabled, the line is dark. The block drives the line both in parallel and as a serial pixel stream at one pixel per dot clock. A display pipeline places one cell per nine dot clocks and presents the code, line number and format for each cell at its boundary.

The base set holds 128 codes. The glyph contents are computed rather than loaded, so every stored byte is a fixed function of code and line. Larger display forms, such as 3 x 3 blocks of cells, are built by an outer stage from ordinary cells.

Top module: `char_row_gen`

## Requirements
- R1: While rst_ni is low, row_o and serial_o are 0.
- R2: The stored byte for code c (7 bits) and line r (4 bits, r < 15) is {c, r[0]} XOR {r, r}, with bit 7 as the MSB.
- R3: For line index 15, the stored byte is 0, so row_o is 0 in every format.
- R4: In alphanumeric format (fmt_i = 0) with stored bit 7 = 0, row_o[8:2] = byte[6:0] and row_o[1:0] = 0.
- R5: In alphanumeric format with stored bit 7 = 1, the glyph moves one pixel right: row_o[7:1] = byte[6:0] and row_o[8] = row_o[0] = 0.
- R6: In full-width format (fmt_i = 1), row_o[8:2] = byte[7:1] and row_o[1] = row_o[0] = byte[0].
- R7: With en_mode_i = 0, the store is enabled only when all four bits of en_i are 1.
- R8: With en_mode_i = 1, the store is enabled when en_i[1:0] = 2'b11 or en_i[3:2] = 2'b11.
- R9: While the store is not enabled, row_o is all zeros.
- R10: row_o is registered. It shows the line for the inputs present at the previous rising clock edge.
- R11: Cells are nine clocks long. The first cell starts at the first rising edge after reset is released. At that edge the line for the current inputs is loaded, and serial_o presents row_o bit 8 first, down to bit 0. Input changes inside a cell do not affect its serial pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 7 | Character code |
| line_i | input | 4 | Scan line within the cell |
| fmt_i | input | 1 | 0 = alphanumeric, 1 = full-width |
| en_i | input | 4 | Four store enables, active high |
| en_mode_i | input | 1 | 0 = all four enables, 1 = either enable pair |
| row_o | output | 9 | Pixel line, bit 8 leftmost |
| serial_o | output | 1 | Serial pixel stream, one pixel per clock |

## Verification
Random codes and lines in both formats exercise both half-shift positions. This separates a mapping error in the alphanumeric path from one in the duplicated-bit path.

Random enable vectors under both enable styles separate the AND-of-four rule from the pair rule. Directed vectors such as 4'b0011, 4'b1100 and 4'b0111 are the ones where the two styles disagree.

Line 15 is tried in both formats to confirm it stays dark. One cell changes its inputs part-way through, which shows that the serial stream keeps the loaded line while row_o follows the new inputs.

// File: rtl/crg_pkg.sv
package crg_pkg;
  localparam int CODE_W  = 7;
  localparam int LINE_W  = 4;
  localparam int STORE_W = 8;
  localparam int CELL_W  = STORE_W + 1;
  localparam int CELL_H  = 15;
  localparam int EN_N    = 4;

  typedef enum logic {FMT_ALPHA = 1'b0, FMT_FULL = 1'b1} fmt_e;
  typedef enum logic {EN_ALL = 1'b0, EN_PAIR = 1'b1} en_mode_e;

  // computed glyph contents: no table needed
  function automatic logic [STORE_W-1:0] glyph_byte(logic [CODE_W-1:0] code,
                                                    logic [LINE_W-1:0] line);
    if (int'(line) >= CELL_H) return '0;
    return {code, line[0]} ^ {line, line};
  endfunction
endpackage

// File: rtl/crg_enable_qual.sv
module crg_enable_qual
  import crg_pkg::*;
#(
  parameter int N = EN_N
) (
  input  logic [N-1:0] en_i,
  input  en_mode_e     mode_i,
  output logic         ok_o
);
  localparam int PAIRS = N / 2;

  logic [PAIRS-1:0] pair_ok;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_ok[p] = en_i[2*p] & en_i[2*p+1];
  end

  always_comb begin
    unique case (mode_i)
      EN_ALL:  ok_o = &en_i;
      EN_PAIR: ok_o = |pair_ok;
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/crg_glyph_store.sv
module crg_glyph_store
  import crg_pkg::*;
(
  input  logic [CODE_W-1:0]  code_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic               cs_i,
  output logic [STORE_W-1:0] data_o
);
  always_comb data_o = cs_i ? glyph_byte(code_i, line_i) : '0;
endmodule

// File: rtl/crg_row_expand.sv
module crg_row_expand
  import crg_pkg::*;
(
  input  logic [STORE_W-1:0] byte_i,
  input  fmt_e               fmt_i,
  output logic [CELL_W-1:0]  pix_o
);
  localparam int GLY_W = STORE_W - 1;

  logic [CELL_W-1:0] alpha_pix, full_pix;
  logic              half;

  assign half = byte_i[STORE_W-1];

  // alpha: 7 pixels at [8:2] or, with half-shift, at [7:1]
  for (genvar i = 0; i < GLY_W; i++) begin : g_alpha
    assign alpha_pix[i+2] = half ? byte_i[i+1] & 1'b0 | (i == GLY_W-1 ? 1'b0 : byte_i[i+1]) : byte_i[i];
  end
  assign alpha_pix[1] = half ? byte_i[0] : 1'b0;
  assign alpha_pix[0] = 1'b0;

  // full: bit 0 doubled into pixels 1 and 0
  for (genvar i = 1; i < STORE_W; i++) begin : g_full
    assign full_pix[i+1] = byte_i[i];
  end
  assign full_pix[1] = byte_i[0];
  assign full_pix[0] = byte_i[0];

  assign pix_o = (fmt_i == FMT_FULL) ? full_pix : alpha_pix;
endmodule

// File: rtl/crg_serializer.sv
module crg_serializer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] load_i,
  output logic         serial_o
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (cnt_q == '0) begin
      sh_q  <= load_i;
      cnt_q <= CW'(1);
    end else begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      cnt_q <= (cnt_q == CW'(W-1)) ? '0 : cnt_q + CW'(1);
    end
  end

  assign serial_o = sh_q[W-1];

  a_r11_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < W);
  a_r11_first_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> serial_o == $past(load_i[W-1]));
  a_r11_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> sh_q[W-2:0] == '0);
endmodule

// File: rtl/char_row_gen.sv
module char_row_gen
  import crg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [LINE_W-1:0]   line_i,
  input  logic                fmt_i,
  input  logic [EN_N-1:0]     en_i,
  input  logic                en_mode_i,
  output logic [CELL_W-1:0]   row_o,
  output logic                serial_o
);
  logic               cs;
  logic [STORE_W-1:0] store_q;
  logic [CELL_W-1:0]  pix_d;
  logic [CELL_W-1:0]  row_q;

  crg_enable_qual #(.N(EN_N)) u_qual (
    .en_i   (en_i),
    .mode_i (en_mode_e'(en_mode_i)),
    .ok_o   (cs)
  );

  crg_glyph_store u_store (
    .code_i (code_i),
    .line_i (line_i),
    .cs_i   (cs),
    .data_o (store_q)
  );

  crg_row_expand u_expand (
    .byte_i (store_q),
    .fmt_i  (fmt_e'(fmt_i)),
    .pix_o  (pix_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else         row_q <= pix_d;
  end
  assign row_o = row_q;

  crg_serializer #(.W(CELL_W)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (pix_d),
    .serial_o (serial_o)
  );

  a_r9_dark_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs |=> row_o == '0);
  a_r3_last_line_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i == LINE_W'(CELL_H)) |=> row_o == '0);
  a_r6_dup_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_FULL) |=> row_o[1] == row_o[0]);
  a_r4_alpha_right_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == FMT_ALPHA) |=> row_o[0] == 1'b0);
  a_r8_pair_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mode_i && en_i[1:0] == 2'b11) |-> cs);
endmodule

// File: tb/char_row_gen_tb_top.sv
`timescale 1ns/1ps
module char_row_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] code = '0;
  logic [3:0] line = '0;
  logic       fmt = 1'b0;
  logic [3:0] en = '0;
  logic       mode = 1'b0;
  logic [8:0] row;
  logic       ser;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  char_row_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .line_i(line), .fmt_i(fmt),
    .en_i(en), .en_mode_i(mode), .row_o(row), .serial_o(ser)
  );

  // R2 R3
  function automatic logic [7:0] ref_byte(logic [6:0] c, logic [3:0] r);
    if (r == 4'd15) return 8'h00;
    return {c, r[0]} ^ {r, r};
  endfunction

  // R7 R8
  function automatic logic ref_en(logic [3:0] e, logic m);
    if (!m) return e == 4'hF;
    return (e[1:0] == 2'b11) || (e[3:2] == 2'b11);
  endfunction

  // R4 R5 R6 R9
  function automatic logic [8:0] ref_row(logic [6:0] c, logic [3:0] r, logic f,
                                         logic [3:0] e, logic m);
    logic [7:0] b;
    if (!ref_en(e, m)) return 9'h000;
    b = ref_byte(c, r);
    if (f) return {b[7:1], b[0], b[0]};
    if (b[7]) return {1'b0, b[6:0], 1'b0};
    return {b[6:0], 2'b00};
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one 9-clock cell; called at a negedge just before the load edge
  task automatic run_cell(string req, logic [6:0] c, logic [3:0] r, logic f,
                          logic [3:0] e, logic m, bit mid, logic [6:0] c2);
    logic [8:0] exp_a, exp_b, got;
    code = c; line = r; fmt = f; en = e; mode = m;
    exp_a = ref_row(c, r, f, e, m);
    exp_b = ref_row(c2, r, f, e, m);
    for (int k = 0; k < 9; k++) begin
      @(posedge clk);
      @(negedge clk);
      got[8-k] = ser;
      if (k == 0) begin
        check({req, " R10 row"}, row, exp_a);
        if (mid) code = c2;
      end
      if (k == 1 && mid) check("R11 row follows new input", row, exp_b);
    end
    check({req, " R11 serial"}, got, exp_a);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    code = 7'h55; line = 4'd3; fmt = 1'b1; en = 4'hF; mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 row in reset", row, 9'h000);
    check("R1 serial in reset", {8'h00, ser}, 9'h000);
    rst_n = 1'b1;

    // directed corners
    run_cell("R4 alpha unshifted", 7'h12, 4'd0, 1'b0, 4'hF, 1'b0, 1'b0, 7'h0);
    run_cell("R5 alpha shifted",   7'h52, 4'd0, 1'b0, 4'hF, 1'b0, 1'b0, 7'h0);
    run_cell("R6 full width",      7'h7F, 4'd4, 1'b1, 4'hF, 1'b0, 1'b0, 7'h0);
    run_cell("R6 full bit0",       7'h00, 4'd1, 1'b1, 4'hF, 1'b0, 1'b0, 7'h0);
    run_cell("R3 line15 full",     7'h7F, 4'd15, 1'b1, 4'hF, 1'b0, 1'b0, 7'h0);
    run_cell("R3 line15 alpha",    7'h2A, 4'd15, 1'b0, 4'hF, 1'b1, 1'b0, 7'h0);
    run_cell("R7 three of four",   7'h33, 4'd2, 1'b1, 4'h7, 1'b0, 1'b0, 7'h0);
    run_cell("R7 pair no all",     7'h33, 4'd2, 1'b1, 4'h3, 1'b0, 1'b0, 7'h0);
    run_cell("R8 low pair",        7'h33, 4'd2, 1'b1, 4'h3, 1'b1, 1'b0, 7'h0);
    run_cell("R8 high pair",       7'h33, 4'd2, 1'b1, 4'hC, 1'b1, 1'b0, 7'h0);
    run_cell("R9 split pairs",     7'h33, 4'd2, 1'b1, 4'h5, 1'b1, 1'b0, 7'h0);
    run_cell("R9 none",            7'h6E, 4'd9, 1'b0, 4'h0, 1'b1, 1'b0, 7'h0);
    run_cell("R2 R11 mid change",  7'h0F, 4'd6, 1'b1, 4'hF, 1'b0, 1'b1, 7'h70);

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [3:0] e;
      e = ($urandom_range(0, 3) == 0) ? 4'($urandom) : (($urandom_range(0, 1) == 1) ? 4'hF : 4'h3);
      run_cell("R2 random", 7'($urandom), 4'($urandom_range(0, 15)),
               1'($urandom), e, 1'($urandom), 1'b0, 7'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule